// File: doc/BRIEF.md
# SMBus clock timeout detector

This block watches the already-synchronised SCL and SDA lines of an I2C/SMBus controller and raises timeout flags for it. It runs on the kernel clock. One shared timer (timer A) serves two purposes, picked by a mode bit. In low-timeout mode it measures how long SCL stays low, with 2048 kernel cycles per count. In idle mode it measures how long both lines stay high, with 4 kernel cycles per count.

A second timer (timer B) adds up the kernel cycles in which this controller itself is stretching SCL low. Its total restarts whenever a START or STOP is seen on the bus. It is role-agnostic: the controller drives `self_stretch` with its master extension in master mode or its slave extension in slave mode.

A single configuration word is written through a valid/ready port and can be read back at any time. The thresholds are locked while their timers run. A write that arrives while an earlier write is still being transferred is stalled. Each flag is sticky and has its own clear pulse.

Top module: `bus_timeout_monitor`

## Requirements
- R1: With timer A enabled and idle mode off, `tout_flag` rises after exactly (THR_A+1)*2048 consecutive clock edges with `scl_in` low.
- R2: With timer A enabled and idle mode on, `idle_flag` rises after exactly (THR_A+1)*4 consecutive clock edges with both `scl_in` and `sda_in` high.
- R3: With timer B enabled, `ext_flag` rises on the edge that completes (THR_B+1)*2048 edges with `self_stretch` high. Edges without stretching add nothing, and they do not reset the total.
- R4: While the timer-A enable reads 1, a write leaves THR_A and the idle-mode bit unchanged. The lock is judged on the enable value held before that write, and the enable bit itself is always written.
- R5: While the timer-B enable reads 1, a write leaves THR_B unchanged. The timer-B enable bit itself is always written.
- R6: A disabled timer never raises its flags, however long its condition holds.
- R7: After a write is accepted, `wr_ready` stays low for WR_LAT cycles (default 3). A second write is held off until `wr_ready` returns high.
- R8: Timer A restarts from zero on any edge where its condition is broken: SCL high in low-timeout mode, or either line low in idle mode.
- R9: A START or STOP clears the timer-B total. Either one is an edge where `sda_in` differs from its previous sampled value while `scl_in` is high now and was high one cycle before.
- R10: Each flag stays set until its clear input is high at an edge. If a set and a clear meet on the same edge, the set wins.
- R11: Once a timer has flagged, it does not flag again until it is re-armed and has counted the full time afresh. Timer A is re-armed by a break of its condition. Timer B is re-armed by a START or STOP.
- R12: The 27-bit configuration word has this layout: THR_A in [11:0], idle-mode bit in [12], timer-A enable in [13], THR_B in [25:14], timer-B enable in [26]. `rd_data` shows the stored word from the edge after acceptance. After reset it reads 0, all flags are low and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| self_stretch | input | 1 | High while this controller holds SCL low to extend the clock |
| wr_valid | input | 1 | Configuration write request |
| wr_data | input | 27 | Configuration word to write |
| wr_ready | output | 1 | Write can be accepted this cycle |
| rd_data | output | 27 | Stored configuration word |
| clr_tout | input | 1 | Clear pulse for `tout_flag` |
| clr_idle | input | 1 | Clear pulse for `idle_flag` |
| clr_ext | input | 1 | Clear pulse for `ext_flag` |
| tout_flag | output | 1 | Sticky SCL-low timeout |
| idle_flag | output | 1 | Sticky bus-idle detect |
| ext_flag | output | 1 | Sticky cumulative stretch timeout |

## Verification
A flag becomes visible just after the Nth clock edge at which its condition held, where N is the threshold formula. Readback changes one edge after the write is accepted. `wr_ready` falls for exactly WR_LAT cycles after that same edge.

The bench drives inputs and samples outputs on falling edges. For each timeout it checks that the flag is still low after N-1 edges and high after N, so a result that arrives one cycle early or late fails. Lock and stall behaviour is checked through `rd_data` and through the number of cycles the bench waits for `wr_ready`.

// File: rtl/bto_pkg.sv
// Shared types for the bus timeout monitor: threshold width and the layout
// of the configuration word (bit order is visible at the write port).
package bto_pkg;
    localparam int TH_W = 12;

    typedef struct packed {
        logic            en_b;
        logic [TH_W-1:0] thr_b;
        logic            en_a;
        logic            idle_sel;
        logic [TH_W-1:0] thr_a;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/bto_cfg_regs.sv
// Configuration register with write locks and a write-transfer stall.
// Assumes WR_LAT >= 1; a write is accepted when wr_valid and wr_ready meet.
module bto_cfg_regs
    import bto_pkg::*;
#(
    parameter int WR_LAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [CFG_W-1:0] wr_data,
    output logic             wr_ready,
    output cfg_t             cfg
);
    localparam int BUSY_W = $clog2(WR_LAT + 1);
    localparam logic [BUSY_W-1:0] BUSY_LOAD = BUSY_W'(WR_LAT);

    cfg_t              cfg_q;
    cfg_t              w;
    logic [BUSY_W-1:0] busy_q;
    logic              accept;

    assign w        = cfg_t'(wr_data);
    assign wr_ready = (busy_q == '0);
    assign accept   = wr_valid && wr_ready;
    assign cfg      = cfg_q;

    // Store accepted writes; threshold fields honour the current enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q.en_a <= w.en_a;
            cfg_q.en_b <= w.en_b;
            if (!cfg_q.en_a) begin
                cfg_q.thr_a    <= w.thr_a;
                cfg_q.idle_sel <= w.idle_sel;
            end
            if (!cfg_q.en_b) begin
                cfg_q.thr_b <= w.thr_b;
            end
        end
    end

    // Count down the transfer time of the last accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)              busy_q <= '0;
        else if (accept)         busy_q <= BUSY_LOAD;
        else if (busy_q != '0)   busy_q <= busy_q - 1'b1;
    end

    a_r4_lock_a: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_q.en_a) |=> ($stable(cfg_q.thr_a) && $stable(cfg_q.idle_sel)));
    a_r5_lock_b: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cfg_q.en_b) |=> $stable(cfg_q.thr_b));
    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !wr_ready);
endmodule

// File: rtl/bto_tick_counter.sv
// Prescaled threshold counter shared by both timers. Counts edges with run
// high; fire is high in the cycle whose edge completes (thr+1)*(pre_last+1)
// counted edges. After firing it stays done until restart or disable.
// Assumes thr and pre_last are stable while en is high.
module bto_tick_counter #(
    parameter int PRE_W = 11,
    parameter int TH_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre_last,
    input  logic [TH_W-1:0]  thr,
    output logic             fire
);
    logic [PRE_W-1:0] pre_q;
    logic [TH_W-1:0]  cnt_q;
    logic             done_q;
    logic             step;
    logic             wrap;

    assign step = en && !restart && run && !done_q;
    assign wrap = (pre_q == pre_last);
    assign fire = step && wrap && (cnt_q == thr);

    // Advance the prescaler and the count; hold zero when idle or restarted.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            pre_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (step) begin
            if (wrap) begin
                pre_q <= '0;
                if (cnt_q == thr) begin
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (en && restart) |=> (pre_q == '0 && cnt_q == '0 && !fire));
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q <= thr && pre_q <= pre_last));
    a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !restart && en) |=> !fire);
endmodule

// File: rtl/bto_sticky_flag.sv
// Sticky flag: set by a one-cycle pulse, cleared by clr; set wins on a tie.
module bto_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold the flag between set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q && !clr) |=> q);
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> q);
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !q);
endmodule

// File: rtl/bus_timeout_monitor.sv
// Bus timeout monitor top. Timer A: SCL-low timeout or bus-idle detect.
// Timer B: cumulative self-stretch time, cleared on START/STOP.
// Assumes scl_in/sda_in are already synchronised to clk.
module bus_timeout_monitor
    import bto_pkg::*;
#(
    parameter int PRE_LOG2 = 11,
    parameter int IDLE_PRE = 4,
    parameter int WR_LAT   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             self_stretch,
    input  logic             wr_valid,
    input  logic [CFG_W-1:0] wr_data,
    output logic             wr_ready,
    output logic [CFG_W-1:0] rd_data,
    input  logic             clr_tout,
    input  logic             clr_idle,
    input  logic             clr_ext,
    output logic             tout_flag,
    output logic             idle_flag,
    output logic             ext_flag
);
    localparam int N_FLAGS = 3;
    localparam logic [PRE_LOG2-1:0] LONG_LAST = {PRE_LOG2{1'b1}};
    localparam logic [PRE_LOG2-1:0] IDLE_LAST = PRE_LOG2'(IDLE_PRE - 1);

    cfg_t               cfg;
    logic               prev_scl_q;
    logic               prev_sda_q;
    logic               bus_event;
    logic               cond_a;
    logic [PRE_LOG2-1:0] last_a;
    logic               fire_a;
    logic               fire_b;
    logic [N_FLAGS-1:0] set_v;
    logic [N_FLAGS-1:0] clr_v;
    logic [N_FLAGS-1:0] flag_v;

    bto_cfg_regs #(.WR_LAT(WR_LAT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .cfg(cfg)
    );
    assign rd_data = cfg;

    // Remember last line levels to spot START/STOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_scl_q <= 1'b1;
            prev_sda_q <= 1'b1;
        end else begin
            prev_scl_q <= scl_in;
            prev_sda_q <= sda_in;
        end
    end

    assign bus_event = scl_in && prev_scl_q && (sda_in != prev_sda_q);
    assign cond_a    = cfg.idle_sel ? (scl_in && sda_in) : !scl_in;
    assign last_a    = cfg.idle_sel ? IDLE_LAST : LONG_LAST;

    bto_tick_counter #(.PRE_W(PRE_LOG2), .TH_W(TH_W)) u_timer_a (
        .clk(clk), .rst_n(rst_n), .en(cfg.en_a), .run(cond_a),
        .restart(!cond_a), .pre_last(last_a), .thr(cfg.thr_a), .fire(fire_a)
    );

    bto_tick_counter #(.PRE_W(PRE_LOG2), .TH_W(TH_W)) u_timer_b (
        .clk(clk), .rst_n(rst_n), .en(cfg.en_b), .run(self_stretch),
        .restart(bus_event), .pre_last(LONG_LAST), .thr(cfg.thr_b), .fire(fire_b)
    );

    assign set_v = {fire_b, fire_a && cfg.idle_sel, fire_a && !cfg.idle_sel};
    assign clr_v = {clr_ext, clr_idle, clr_tout};

    for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
        bto_sticky_flag u_flag (
            .clk(clk), .rst_n(rst_n), .set(set_v[g]), .clr(clr_v[g]), .q(flag_v[g])
        );
    end

    assign tout_flag = flag_v[0];
    assign idle_flag = flag_v[1];
    assign ext_flag  = flag_v[2];

    a_r6_a_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en_a |=> (!$rose(tout_flag) && !$rose(idle_flag)));
    a_r6_b_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en_b |=> !$rose(ext_flag));
    a_r9_event_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_event && !ext_flag && !clr_ext) |=> !ext_flag);
endmodule

// File: tb/test_bus_timeout_monitor.sv
module test_bus_timeout_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_in = 1'b1, sda_in = 1'b1, self_stretch = 1'b0;
    logic        wr_valid = 1'b0;
    logic [26:0] wr_data = '0;
    logic        wr_ready;
    logic [26:0] rd_data;
    logic        clr_tout = 1'b0, clr_idle = 1'b0, clr_ext = 1'b0;
    logic        tout_flag, idle_flag, ext_flag;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    bus_timeout_monitor i_bus_timeout_monitor (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .self_stretch(self_stretch), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_data(rd_data), .clr_tout(clr_tout),
        .clr_idle(clr_idle), .clr_ext(clr_ext), .tout_flag(tout_flag),
        .idle_flag(idle_flag), .ext_flag(ext_flag)
    );

    // Vectors: {idle mode, THR_A, expected edges until flag}.
    localparam logic [29:0] VEC [6] = '{
        {1'b0, 12'd0,    17'd2048},
        {1'b0, 12'd1,    17'd4096},
        {1'b0, 12'd2,    17'd6144},
        {1'b1, 12'd0,    17'd4},
        {1'b1, 12'd5,    17'd24},
        {1'b1, 12'd4095, 17'd16384}
    };

    function automatic logic [26:0] mk(input logic enb, input logic [11:0] tb,
                                       input logic ena, input logic idl,
                                       input logic [11:0] ta);
        return {enb, tb, ena, idl, ta};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [26:0] d, output int stalls);
        stalls = 0;
        wr_valid = 1'b1;
        wr_data  = d;
        while (!wr_ready) begin
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int s1, s2;
        edges(3);
        rst_n = 1'b1;
        edges(1);
        // R12 reset state
        chk("R12 reset rd_data", rd_data, 0);
        chk("R12 reset flags", {tout_flag, idle_flag, ext_flag}, 0);
        chk("R12 reset wr_ready", wr_ready, 1);

        // Vector table: R1 / R2 timing
        for (int i = 0; i < 6; i++) begin
            logic        md;
            logic [11:0] th;
            int          cyc;
            md  = VEC[i][29];
            th  = VEC[i][28:17];
            cyc = int'(VEC[i][16:0]);
            scl_in = md ? 1'b0 : 1'b1;
            sda_in = 1'b1;
            wr(27'd0, s1);
            wr(mk(1'b0, 12'd0, 1'b1, md, th), s1);
            chk("R12 readback", rd_data, mk(1'b0, 12'd0, 1'b1, md, th));
            scl_in = md ? 1'b1 : 1'b0;
            edges(cyc - 1);
            chk(md ? "R2 idle early" : "R1 low early", md ? idle_flag : tout_flag, 0);
            edges(1);
            chk(md ? "R2 idle due" : "R1 low due", md ? idle_flag : tout_flag, 1);
            scl_in = md ? 1'b0 : 1'b1;
            clr_tout = 1'b1; clr_idle = 1'b1;
            edges(1);
            clr_tout = 1'b0; clr_idle = 1'b0;
            chk("R10 cleared", {tout_flag, idle_flag}, 0);
        end

        // R8 restart on break, low mode THR_A=0
        scl_in = 1'b1;
        wr(27'd0, s1);
        wr(mk(1'b0, 12'd0, 1'b1, 1'b0, 12'd0), s1);
        scl_in = 1'b0; edges(2000);
        scl_in = 1'b1; edges(1);
        scl_in = 1'b0; edges(2047);
        chk("R8 restart early", tout_flag, 0);
        edges(1);
        chk("R8 restart due", tout_flag, 1);
        scl_in = 1'b1; clr_tout = 1'b1; edges(1); clr_tout = 1'b0;
        chk("R10 clear", tout_flag, 0);

        // R10 set wins over simultaneous clear
        scl_in = 1'b0; edges(2047);
        clr_tout = 1'b1; edges(1); clr_tout = 1'b0;
        chk("R10 set wins", tout_flag, 1);
        // R11 no re-flag while condition holds
        clr_tout = 1'b1; edges(1); clr_tout = 1'b0;
        chk("R10 clear while low", tout_flag, 0);
        edges(3000);
        chk("R11 no refire", tout_flag, 0);
        scl_in = 1'b1; edges(1);
        scl_in = 1'b0; edges(2048);
        chk("R11 rearmed", tout_flag, 1);
        scl_in = 1'b1; clr_tout = 1'b1; edges(1); clr_tout = 1'b0;

        // R4 lock of THR_A and idle bit while enabled
        wr(mk(1'b0, 12'd0, 1'b1, 1'b1, 12'd9), s1);
        chk("R4 locked fields", rd_data, mk(1'b0, 12'd0, 1'b1, 1'b0, 12'd0));
        wr(mk(1'b0, 12'd0, 1'b0, 1'b1, 12'd9), s1);
        chk("R4 judged on old enable", rd_data, 27'd0);
        wr(mk(1'b0, 12'd0, 1'b0, 1'b1, 12'd9), s1);
        chk("R4 unlocked write", rd_data, mk(1'b0, 12'd0, 1'b0, 1'b1, 12'd9));

        // R6 disabled timer A never flags
        scl_in = 1'b1; sda_in = 1'b1; edges(200);
        chk("R6 idle disabled", idle_flag, 0);
        wr(27'd0, s1);
        scl_in = 1'b0; edges(5000);
        chk("R6 low disabled", tout_flag, 0);
        scl_in = 1'b1;

        // R7 back-to-back writes stall
        edges(5);
        wr(mk(1'b0, 12'd3, 1'b0, 1'b0, 12'd0), s1);
        wr(mk(1'b0, 12'd1, 1'b0, 1'b0, 12'd0), s2);
        chk("R7 first no stall", s1, 0);
        chk("R7 second stall", s2, 3);

        // R5 lock of THR_B
        wr(mk(1'b1, 12'd1, 1'b0, 1'b0, 12'd0), s1);
        wr(mk(1'b1, 12'd7, 1'b0, 1'b0, 12'd0), s1);
        chk("R5 THR_B locked", rd_data, mk(1'b1, 12'd1, 1'b0, 1'b0, 12'd0));

        // R3 cumulative stretch, THR_B=1 -> 4096
        self_stretch = 1'b1; edges(3000);
        self_stretch = 1'b0; edges(200);
        self_stretch = 1'b1; edges(1095);
        chk("R3 ext early", ext_flag, 0);
        edges(1);
        chk("R3 ext due", ext_flag, 1);
        self_stretch = 1'b0;
        clr_ext = 1'b1; edges(1); clr_ext = 1'b0;
        chk("R10 ext clear", ext_flag, 0);
        self_stretch = 1'b1; edges(5000); self_stretch = 1'b0;
        chk("R11 ext no refire", ext_flag, 0);

        // R9 START/STOP clears total
        sda_in = 1'b0; edges(2);
        sda_in = 1'b1; edges(2);
        self_stretch = 1'b1; edges(3000); self_stretch = 1'b0;
        sda_in = 1'b0; edges(1);
        sda_in = 1'b1; edges(1);
        self_stretch = 1'b1; edges(4095);
        chk("R9 total cleared", ext_flag, 0);
        edges(1);
        chk("R9 full count", ext_flag, 1);
        self_stretch = 1'b0;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule